// File: doc/BRIEF.md
# Memory-Mapped Compare Timer Frame

A single timer frame on a 32-bit register bus. It keeps a free-running 64-bit system count that advances on an external count-enable tick. It also derives a virtual count by subtracting a static 64-bit offset input. Two independent one-shot compare timers watch these counts. The physical timer compares against the system count and the virtual timer compares against the virtual count. Each timer drives its own level interrupt.

Software reads the 64-bit counts and compare values as pairs of 32-bit words. Because the count keeps moving between the two halves, software reads high, low, high, and retries until the two high words agree. To arm a timer, software disables it, writes both compare halves, and then enables it with the mask cleared. A firing is acknowledged by setting the mask bit.

A permission vector from the neighbouring access-control block gates each register group. The frame also reports a fixed count frequency.

Top module: `mmio_cmp_timer`

## Requirements
- R1: The system count resets to the parameter `CNT_RST` and rises by exactly one on each clock where `tick_i` is high. It holds when `tick_i` is low. It reads at word offset 0x00 (bits 31:0) and 0x04 (bits 63:32).
- R2: The virtual count equals the system count minus `voff_i`, modulo 2^64. It reads at 0x08 (low) and 0x0C (high).
- R3: Offset 0x10 returns the parameter `FREQ_HZ`. Writes to it have no effect.
- R4: The physical compare value is at 0x20 (low) and 0x24 (high), and the virtual one is at 0x30 (low) and 0x34 (high). Each half is written on its own, the other half keeps its value, and both read back. They reset to zero.
- R5: The control words sit at 0x2C (physical) and 0x3C (virtual). Bit 0 is enable and bit 1 is mask; both are writable and reset to 0. Bit 2 is status and is read-only. Writes to bit 2 and to bits 31:3 are ignored, and bits 31:3 read as zero.
- R6: Status is 1 exactly when enable is set and the timer's own count is greater than or equal to its compare value, as an unsigned 64-bit comparison. The physical timer uses the system count and the virtual timer uses the virtual count. Status is 0 while disabled.
- R7: Each interrupt output (`irq_phys_o`, `irq_virt_o`) equals status AND NOT mask as a level. It stays high until the condition clears, and setting the mask drops it.
- R8: The bits of `perm_i` gate access as follows: bit 0 the system count, bit 1 the virtual count, bit 2 the frequency, bit 3 the physical timer registers, and bit 4 the virtual timer registers. When a group's bit is clear, its reads return zero and its writes are ignored.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.
- R10: The 64-bit count carries from the low word into the high word. A high-low-high read whose two high words agree yields the count as it stood at the low-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable tick |
| perm_i | input | 5 | Access permission per register group |
| voff_i | input | 64 | Static virtual offset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset (bits 1:0 ignored) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| irq_phys_o | output | 1 | Physical timer interrupt level |
| irq_virt_o | output | 1 | Virtual timer interrupt level |

## Verification
The bench starts the count just below a 32-bit carry and runs high-low-high reads across it. A design that did not ripple the carry, or that latched the halves separately, would return a combined value inconsistent with the count. The virtual timer is armed with a compare value that the system count already exceeds, so a timer that compared against the wrong count would fire at once. A compare value with bit 63 set must not fire, which catches a signed comparison. Permission-gated and unmapped writes are followed by read-back to show that no register moved, and status is checked after the mask is set and after the enable is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;
  localparam int VW = 64;
  // word indices (byte offset >> 2)
  localparam logic [5:0] W_PCNT_LO = 6'h00;
  localparam logic [5:0] W_PCNT_HI = 6'h01;
  localparam logic [5:0] W_VCNT_LO = 6'h02;
  localparam logic [5:0] W_VCNT_HI = 6'h03;
  localparam logic [5:0] W_FREQ    = 6'h04;
  localparam logic [5:0] W_CH_BASE = 6'h08;
  localparam int         CH_STRIDE = 4;
  localparam logic [5:0] CH_CV_LO  = 6'd0;
  localparam logic [5:0] CH_CV_HI  = 6'd1;
  localparam logic [5:0] CH_CTL    = 6'd3;
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
  localparam int PERM_PCNT = 0;
  localparam int PERM_VCNT = 1;
  localparam int PERM_FREQ = 2;
  localparam int PERM_CH0  = 3;
  localparam int N_CH      = 2;
  localparam int PERM_W    = PERM_CH0 + N_CH;
endpackage

// File: rtl/tmr_sys_count.sv
module tmr_sys_count #(
  parameter int               CNT_W   = 64,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= RST_VAL;
    else if (tick_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  assert_count_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] cnt_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_ctl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [VW-1:0] cval_o,
  output logic          en_o,
  output logic          mask_o,
  output logic          stat_o,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cval_o <= '0;
      en_o   <= 1'b0;
      mask_o <= 1'b0;
    end else begin
      if (wr_lo_i) cval_o[DW-1:0]  <= wdata_i;
      if (wr_hi_i) cval_o[VW-1:DW] <= wdata_i;
      if (wr_ctl_i) begin
        en_o   <= wdata_i[CTL_EN];
        mask_o <= wdata_i[CTL_MASK];
      end
    end
  end

  // unsigned compare; status forced low while disabled
  assign stat_o = en_o && (cnt_i >= cval_o);
  assign irq_o  = stat_o && !mask_o;

  assert_ctl_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> (en_o == $past(wdata_i[CTL_EN])) && (mask_o == $past(wdata_i[CTL_MASK])));
  assert_cval_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> $stable(cval_o));
  assert_ctl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctl_i |=> $stable(en_o) && $stable(mask_o));
endmodule

// File: rtl/mmio_cmp_timer.sv
module mmio_cmp_timer
  import tmr_pkg::*;
#(
  parameter int            CNT_W   = 64,
  parameter logic [63:0]   CNT_RST = 64'd0,
  parameter logic [31:0]   FREQ_HZ = 32'd50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic [63:0]       voff_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_phys_o,
  output logic              irq_virt_o
);
  logic [5:0]            widx;
  logic                  rd_en, wr_en;
  logic [CNT_W-1:0]      cnt_raw;
  logic [VW-1:0]         pcnt, vcnt;
  logic [N_CH-1:0][VW-1:0] ch_cnt;
  logic [N_CH-1:0][DW-1:0] ch_rd;
  logic [N_CH-1:0]       irq_w;
  logic [DW-1:0]         base_rd;
  logic                  unused_addr;

  assign widx        = addr_i[7:2];
  assign rd_en       = req_i && !we_i;
  assign wr_en       = req_i && we_i;
  assign unused_addr = ^addr_i[1:0];

  tmr_sys_count #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(CNT_RST))) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_raw)
  );

  assign pcnt      = VW'(cnt_raw);
  assign vcnt      = pcnt - voff_i;
  assign ch_cnt[0] = pcnt;
  assign ch_cnt[1] = vcnt;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [5:0] BASE = W_CH_BASE + 6'(CH_STRIDE * g);
    logic          ok;
    logic [VW-1:0] cval;
    logic          en, mask, stat;

    assign ok = perm_i[PERM_CH0+g];

    tmr_cmp_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (ch_cnt[g]),
      .wr_lo_i  (wr_en && ok && widx == BASE + CH_CV_LO),
      .wr_hi_i  (wr_en && ok && widx == BASE + CH_CV_HI),
      .wr_ctl_i (wr_en && ok && widx == BASE + CH_CTL),
      .wdata_i  (wdata_i),
      .cval_o   (cval),
      .en_o     (en),
      .mask_o   (mask),
      .stat_o   (stat),
      .irq_o    (irq_w[g])
    );

    assign ch_rd[g] = !(rd_en && ok)             ? '0 :
                      (widx == BASE + CH_CV_LO) ? cval[DW-1:0] :
                      (widx == BASE + CH_CV_HI) ? cval[VW-1:DW] :
                      (widx == BASE + CH_CTL)   ? {29'd0, stat, mask, en} : '0;

    assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_w[g] |-> en && !mask && (ch_cnt[g] >= cval));
    assert_off_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en |-> !irq_w[g] && !stat);
  end

  always_comb begin
    base_rd = '0;
    case (widx)
      W_PCNT_LO: base_rd = perm_i[PERM_PCNT] ? pcnt[DW-1:0]  : '0;
      W_PCNT_HI: base_rd = perm_i[PERM_PCNT] ? pcnt[VW-1:DW] : '0;
      W_VCNT_LO: base_rd = perm_i[PERM_VCNT] ? vcnt[DW-1:0]  : '0;
      W_VCNT_HI: base_rd = perm_i[PERM_VCNT] ? vcnt[VW-1:DW] : '0;
      W_FREQ:    base_rd = perm_i[PERM_FREQ] ? FREQ_HZ       : '0;
      default:   base_rd = '0;
    endcase
    if (!rd_en) base_rd = '0;
  end

  assign rdata_o    = base_rd | ch_rd[0] | ch_rd[1];
  assign irq_phys_o = irq_w[0];
  assign irq_virt_o = irq_w[1];

  assert_perm_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && widx == W_PCNT_LO && !perm_i[PERM_PCNT]) |-> rdata_o == '0);
  assert_idle_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0);
endmodule

// File: tb/test_mmio_cmp_timer.sv
module test_mmio_cmp_timer;
  localparam logic [63:0] CNT_RST = 64'h0000_0000_FFFF_FF00;
  localparam logic [31:0] FREQ_HZ = 32'd24_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  perm = 5'b11111;
  logic [63:0] voff = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_p, irq_v;
  logic [63:0] m_cnt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_cnt <= CNT_RST;
    else if (tick) m_cnt <= m_cnt + 64'd1;

  mmio_cmp_timer #(.CNT_W(64), .CNT_RST(CNT_RST), .FREQ_HZ(FREQ_HZ)) i_mmio_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .perm_i(perm), .voff_i(voff),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_phys_o(irq_p), .irq_virt_o(irq_v)
  );

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 reset lo", d, CNT_RST[31:0]);
    rd(8'h04, d); check("R1 reset hi", d, CNT_RST[63:32]);
    rd(8'h20, d); check("R4 reset cval", d, 0);
    rd(8'h34, d); check("R4 reset vcval", d, 0);
    rd(8'h2C, d); check("R5 reset ctl", d, 0);
    check("R7 reset irq", {irq_p, irq_v}, 0);
  endtask

  task automatic t_count;
    logic [31:0] d, e;
    tick = 1'b1;
    repeat (10) @(negedge clk);
    rd(8'h00, d); check("R1 running", d, m_cnt[31:0]);
    tick = 1'b0;
    rd(8'h00, d);
    repeat (5) @(negedge clk);
    rd(8'h00, e); check("R1 hold", e, d);
  endtask

  task automatic t_carry;
    logic [31:0] h1, lo, h2;
    logic [63:0] snap;
    bit seen = 0;
    tick = 1'b1;
    for (int k = 0; k < 400 && !seen; k++) begin
      rd(8'h04, h1);
      rd(8'h00, lo); snap = m_cnt;
      rd(8'h04, h2);
      if (h1 == h2) check("R10 hlh consistent", {h1, lo}, snap);
      if (h2 != CNT_RST[63:32]) seen = 1;
    end
    check("R10 carry seen", 64'(seen), 64'd1);
    tick = 1'b0;
    rd(8'h04, h1); check("R10 hi after carry", h1, m_cnt[63:32]);
    rd(8'h00, lo); check("R10 lo after carry", lo, m_cnt[31:0]);
  endtask

  task automatic t_virt;
    logic [31:0] d;
    logic [63:0] e;
    voff = 64'h0000_0001_0000_0010;
    e = m_cnt - voff;
    rd(8'h08, d); check("R2 vcnt lo", d, e[31:0]);
    rd(8'h0C, d); check("R2 vcnt hi", d, e[63:32]);
    voff = 64'h0;
  endtask

  task automatic t_freq;
    logic [31:0] d;
    rd(8'h10, d); check("R3 freq", d, FREQ_HZ);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, d); check("R3 freq write ignored", d, FREQ_HZ);
  endtask

  task automatic t_cval;
    logic [31:0] d;
    wr(8'h20, 32'hA1A2_A3A4); wr(8'h24, 32'hB1B2_B3B4);
    wr(8'h30, 32'hC1C2_C3C4); wr(8'h34, 32'hD1D2_D3D4);
    rd(8'h20, d); check("R4 pcval lo", d, 32'hA1A2_A3A4);
    rd(8'h24, d); check("R4 pcval hi", d, 32'hB1B2_B3B4);
    rd(8'h30, d); check("R4 vcval lo", d, 32'hC1C2_C3C4);
    rd(8'h34, d); check("R4 vcval hi", d, 32'hD1D2_D3D4);
    wr(8'h20, 32'h0000_0042);
    rd(8'h24, d); check("R4 hi kept", d, 32'hB1B2_B3B4);
  endtask

  task automatic t_ctl;
    logic [31:0] d;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, d); check("R5 ctl upper/stat ignored", d, 32'h3);
    wr(8'h2C, 32'h4);
    rd(8'h2C, d); check("R5 stat not writable", d, 32'h0);
  endtask

  task automatic t_phys_fire;
    logic [31:0] d;
    logic [63:0] tgt;
    tick = 1'b1;
    wr(8'h2C, 32'h0);
    tgt = m_cnt + 64'd30;
    wr(8'h20, tgt[31:0]); wr(8'h24, tgt[63:32]);
    wr(8'h2C, 32'h1);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk); #1;
      check("R7 phys irq level", 64'(irq_p), 64'(m_cnt >= tgt));
    end
    tick = 1'b0;
    rd(8'h2C, d); check("R6 status set", d, 32'h5);
    wr(8'h2C, 32'h3);
    #1 check("R7 mask drops irq", 64'(irq_p), 0);
    rd(8'h2C, d); check("R7 masked still status", d, 32'h7);
    wr(8'h2C, 32'h0);
    rd(8'h2C, d); check("R6 disabled status 0", d, 32'h0);
    wr(8'h20, 32'h0); wr(8'h24, 32'h8000_0000);
    wr(8'h2C, 32'h1);
    rd(8'h2C, d); check("R6 unsigned compare", d, 32'h1);
    #1 check("R6 no irq at big cval", 64'(irq_p), 0);
    wr(8'h2C, 32'h0);
  endtask

  task automatic t_virt_fire;
    logic [63:0] tgt;
    voff = 64'h0000_0000_0100_0000;
    tick = 1'b1;
    wr(8'h3C, 32'h0);
    tgt = m_cnt - voff + 64'd20;
    wr(8'h30, tgt[31:0]); wr(8'h34, tgt[63:32]);
    wr(8'h3C, 32'h1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      check("R6 virt uses vcnt", 64'(irq_v), 64'((m_cnt - voff) >= tgt));
      check("R7 phys idle", 64'(irq_p), 0);
    end
    tick = 1'b0;
    wr(8'h3C, 32'h0);
    #1 check("R6 virt disable clears", 64'(irq_v), 0);
  endtask

  task automatic t_perm;
    logic [31:0] d;
    wr(8'h20, 32'h1111_2222);
    wr(8'h2C, 32'h0);
    perm = 5'b00000;
    rd(8'h00, d); check("R8 pcnt gated", d, 0);
    rd(8'h0C, d); check("R8 vcnt gated", d, 0);
    rd(8'h10, d); check("R8 freq gated", d, 0);
    rd(8'h20, d); check("R8 cval gated", d, 0);
    wr(8'h20, 32'h9999_9999);
    wr(8'h2C, 32'h3);
    perm = 5'b01000;
    rd(8'h20, d); check("R8 write ignored", d, 32'h1111_2222);
    rd(8'h2C, d); check("R8 ctl write ignored", d, 32'h0);
    rd(8'h10, d); check("R8 freq still gated", d, 0);
    perm = 5'b11111;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h18, d); check("R9 unmapped 0x18", d, 0);
    rd(8'h28, d); check("R9 unmapped 0x28", d, 0);
    rd(8'hFC, d); check("R9 unmapped 0xFC", d, 0);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h2C, d); check("R9 ctl untouched", d, 0);
    rd(8'h3C, d); check("R9 vctl untouched", d, 0);
    rd(8'h20, d); check("R9 cval untouched", d, 32'h1111_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_carry;
    t_virt;
    t_freq;
    t_cval;
    t_ctl;
    t_phys_fire;
    t_virt_fire;
    t_perm;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=complete");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule